// File: doc/BRIEF.md
# Four-Thread Issue Selector

This block decides, on every clock cycle, which of four hardware threads may issue one instruction into a shared single-issue pipeline. Changing from one thread to another costs no cycles. The grant is worked out from the inputs of the current cycle and from registered per-thread state, so a thread that is ready can be granted in the cycle it becomes ready.

Among the threads that may issue, the one granted longest ago wins. A thread whose next instruction is speculative ranks below every eligible thread whose next instruction is not. A thread is taken out of selection when it starts a multi-cycle multiply or divide, and it stays out until that operation reports completion. A thread is also taken out when the memory stage reports a late trap for it. In that case the block raises a one-cycle flush pulse for that thread only, and the thread stays out until the trap is reported as resolved. Fetch, the per-thread instruction buffers and the functional units connect to this block only through the ready, speculative and event flags.

Top module: `tsel_arbiter`

## Requirements
- R1: After reset no thread is held out of selection and `flush` is all zeros. `grant` never has more than one bit set, and `issue_vld` is high exactly when some bit of `grant` is set.
- R2: The age order after reset, from oldest to youngest, is thread 0, 1, 2, 3. Among eligible non-speculative threads, the oldest one is granted in the same cycle. Bit i of every vector belongs to thread i.
- R3: The granted thread becomes the youngest. With all four threads ready and none speculative, grants rotate in the order 0, 1, 2, 3, 0.
- R4: A thread whose `thr_spec` bit is high is granted only when no eligible thread has `thr_spec` low. Among speculative threads, the oldest one wins.
- R5: A `lat_start` pulse for a thread keeps that thread from being granted from the next cycle on. A `lat_done` pulse makes the thread eligible again in the cycle after the pulse.
- R6: A `trap` pulse for a thread in cycle n makes `flush` high for that thread only, in cycle n+1, for one cycle. The thread is not granted from cycle n+1 until the cycle after a `trap_clr` pulse for it.
- R7: When a deselect event (`lat_start` or `trap`) and the matching reselect event (`lat_done` or `trap_clr`) arrive for the same thread in the same cycle, the thread ends up deselected.
- R8: When no thread is eligible, `grant` is all zeros and `issue_vld` is low, which gives a bubble. The age order changes only in cycles where a thread is granted.
- R9: A thread whose `thr_ready` bit is low is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| thr_ready | input | 4 | The thread has an instruction available to issue |
| thr_spec | input | 4 | The thread's next instruction was fetched after an unresolved load |
| lat_start | input | 4 | A multiply or divide of the thread starts (deselect) |
| lat_done | input | 4 | The thread's multiply or divide has completed (reselect) |
| trap | input | 4 | Late trap reported for the thread (deselect and flush) |
| trap_clr | input | 4 | The thread's trap has been resolved (reselect) |
| grant | output | 4 | One-hot selection of the thread that issues this cycle |
| issue_vld | output | 1 | An instruction issues this cycle |
| flush | output | 4 | One-cycle pulse that discards the thread's younger instructions |

## Verification
The assertions take the event inputs as cycle-wide pulses sampled at the rising edge. They assume that a deselect for a thread is meant to keep that thread out of the following cycle whether or not a reselect arrives with it. They place no limit on which threads may receive events in the same cycle. The stimulus changes every input just after a falling edge and leaves it unchanged through the next rising edge, so each event is seen by exactly one edge. The bench compares the grant, the strobe and the flush vector half a cycle before that edge, against an age order that it tracks by hand from the reset order.

// File: rtl/tsel_pkg.sv
// Package: shared sizing for the thread-select arbiter.
// Assumes the pipeline serves a small, fixed number of threads.
package tsel_pkg;
    parameter int NTHR = 4;
endpackage

// File: rtl/tsel_lru.sv
// Module: tsel_lru
// Keeps a pairwise age matrix. older[i][j] is set when thread i was
// granted less recently than thread j. The granted thread becomes the
// youngest. Assumes that grant is one-hot or zero.
module tsel_lru #(
    parameter int NTHR = tsel_pkg::NTHR
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NTHR-1:0]            grant,
    output logic [NTHR-1:0][NTHR-1:0]  older
);
    for (genvar i = 0; i < NTHR; i++) begin : g_row
        for (genvar j = 0; j < NTHR; j++) begin : g_col
            if (i == j) begin : g_diag
                assign older[i][j] = 1'b0;
            end else begin : g_pair
                logic bit_q;
                // Age relation of one pair: reset order, then update on grant.
                always_ff @(posedge clk) begin
                    if (!rst_n)        bit_q <= (i < j);
                    else if (grant[i]) bit_q <= 1'b0;
                    else if (grant[j]) bit_q <= 1'b1;
                end
                assign older[i][j] = bit_q;
            end
        end
    end
endmodule

// File: rtl/tsel_state.sv
// Module: tsel_state
// Per-thread hold-off state. Each thread has one flag for a pending
// long-latency operation and one for an unresolved late trap. When a
// deselect and a reselect arrive together, the deselect wins. The flush
// pulse is the trap input delayed by one cycle.
module tsel_state #(
    parameter int NTHR = tsel_pkg::NTHR
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NTHR-1:0] lat_start,
    input  logic [NTHR-1:0] lat_done,
    input  logic [NTHR-1:0] trap,
    input  logic [NTHR-1:0] trap_clr,
    output logic [NTHR-1:0] blocked,
    output logic [NTHR-1:0] flush
);
    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        logic lat_wait_q;
        logic trap_wait_q;
        logic flush_q;

        // Long-latency hold: set on start, cleared on done; set wins.
        always_ff @(posedge clk) begin
            if (!rst_n)            lat_wait_q <= 1'b0;
            else if (lat_start[t]) lat_wait_q <= 1'b1;
            else if (lat_done[t])  lat_wait_q <= 1'b0;
        end

        // Trap hold: set on trap, cleared on resolve; set wins.
        always_ff @(posedge clk) begin
            if (!rst_n)           trap_wait_q <= 1'b0;
            else if (trap[t])     trap_wait_q <= 1'b1;
            else if (trap_clr[t]) trap_wait_q <= 1'b0;
        end

        // One-cycle flush pulse for the trapping thread.
        always_ff @(posedge clk) begin
            if (!rst_n) flush_q <= 1'b0;
            else        flush_q <= trap[t];
        end

        assign blocked[t] = lat_wait_q | trap_wait_q;
        assign flush[t]   = flush_q;
    end
endmodule

// File: rtl/tsel_pick.sv
// Module: tsel_pick
// Combinational choice. Non-speculative eligible threads are tried
// first and speculative ones only when none of those exist. Inside the
// chosen pool the thread that is older than every other pool member wins.
// Assumes that older is a consistent total order.
module tsel_pick #(
    parameter int NTHR = tsel_pkg::NTHR
) (
    input  logic [NTHR-1:0]           elig,
    input  logic [NTHR-1:0]           spec,
    input  logic [NTHR-1:0][NTHR-1:0] older,
    output logic [NTHR-1:0]           grant
);
    logic [NTHR-1:0] pool_ns;
    logic [NTHR-1:0] pool;

    // Pool choice: the speculative threads only as a fallback.
    always_comb begin
        pool_ns = elig & ~spec;
        pool    = (|pool_ns) ? pool_ns : elig;
    end

    for (genvar i = 0; i < NTHR; i++) begin : g_win
        logic [NTHR-1:0] beats;
        for (genvar j = 0; j < NTHR; j++) begin : g_cmp
            if (i == j) begin : g_self
                assign beats[j] = 1'b1;
            end else begin : g_other
                assign beats[j] = ~pool[j] | older[i][j];
            end
        end
        assign grant[i] = pool[i] & (&beats);
    end
endmodule

// File: rtl/tsel_arbiter.sv
// Module: tsel_arbiter (top)
// Chooses one of NTHR threads to issue each cycle into a shared pipeline.
// Eligible means ready and not held off. The grant is combinational, so
// a switch of thread costs no cycles. Assumes event inputs are one-cycle
// pulses that are sampled at the rising edge.
module tsel_arbiter #(
    parameter int NTHR = tsel_pkg::NTHR
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NTHR-1:0] thr_ready,
    input  logic [NTHR-1:0] thr_spec,
    input  logic [NTHR-1:0] lat_start,
    input  logic [NTHR-1:0] lat_done,
    input  logic [NTHR-1:0] trap,
    input  logic [NTHR-1:0] trap_clr,
    output logic [NTHR-1:0] grant,
    output logic            issue_vld,
    output logic [NTHR-1:0] flush
);
    logic [NTHR-1:0]           blocked;
    logic [NTHR-1:0]           elig;
    logic [NTHR-1:0][NTHR-1:0] older;

    tsel_state #(.NTHR(NTHR)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .lat_start (lat_start),
        .lat_done  (lat_done),
        .trap      (trap),
        .trap_clr  (trap_clr),
        .blocked   (blocked),
        .flush     (flush)
    );

    // Eligibility: ready and not held off.
    assign elig = thr_ready & ~blocked;

    tsel_pick #(.NTHR(NTHR)) u_pick (
        .elig  (elig),
        .spec  (thr_spec),
        .older (older),
        .grant (grant)
    );

    tsel_lru #(.NTHR(NTHR)) u_lru (
        .clk   (clk),
        .rst_n (rst_n),
        .grant (grant),
        .older (older)
    );

    // Issue strobe: any grant.
    assign issue_vld = |grant;
endmodule

// File: rtl/tsel_arbiter_chk.sv
// Module: tsel_arbiter_chk
// Checker bound to tsel_arbiter. It watches only the ports of the top.
module tsel_arbiter_chk #(
    parameter int NTHR = tsel_pkg::NTHR
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NTHR-1:0] thr_ready,
    input logic [NTHR-1:0] lat_start,
    input logic [NTHR-1:0] trap,
    input logic [NTHR-1:0] grant,
    input logic            issue_vld,
    input logic [NTHR-1:0] flush
);
    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (issue_vld == (grant != '0)));

    // R9
    grant_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~thr_ready) == '0);

    // R5
    lat_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_start != '0) |=> ((grant & $past(lat_start)) == '0));

    // R6
    trap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap != '0) |=> ((grant & $past(trap)) == '0) && ((flush & $past(trap)) == $past(trap)));

    // R8
    bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_ready == '0) |-> !issue_vld);
endmodule

bind tsel_arbiter tsel_arbiter_chk #(.NTHR(NTHR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .thr_ready (thr_ready),
    .lat_start (lat_start),
    .trap      (trap),
    .grant     (grant),
    .issue_vld (issue_vld),
    .flush     (flush)
);

// File: tb/test_tsel_arbiter.sv
module test_tsel_arbiter;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] thr_ready = '0, thr_spec = '0, lat_start = '0, lat_done = '0;
    logic [3:0] trap = '0, trap_clr = '0;
    logic [3:0] grant, flush;
    logic       issue_vld;
    int         n_chk = 0, n_err = 0;
    bit         done = 1'b0;

    tsel_arbiter i_tsel_arbiter (
        .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready), .thr_spec(thr_spec),
        .lat_start(lat_start), .lat_done(lat_done), .trap(trap), .trap_clr(trap_clr),
        .grant(grant), .issue_vld(issue_vld), .flush(flush)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Advance one cycle; return just after the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_ev();
        lat_start = '0; lat_done = '0; trap = '0; trap_clr = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; thr_ready = '0; thr_spec = '0; clear_ev();
        step(); step();
        rst_n = 1'b1;
    endtask

    // R1 R8 R2: the state after reset and a first grant
    task automatic t_reset();
        do_reset();
        #1;
        chk("R1", "grant idle", grant, 4'b0000);
        chk("R8", "vld idle", {3'b0, issue_vld}, 4'b0000);
        chk("R1", "flush reset", flush, 4'b0000);
        thr_ready = 4'b1111; #1;
        chk("R2", "oldest first", grant, 4'b0001);
        chk("R1", "vld on grant", {3'b0, issue_vld}, 4'b0001);
    endtask

    // R3: rotation with all threads ready
    task automatic t_rotate();
        do_reset();
        thr_ready = 4'b1111; #1;
        chk("R3", "rot0", grant, 4'b0001); step(); #1;
        chk("R3", "rot1", grant, 4'b0010); step(); #1;
        chk("R3", "rot2", grant, 4'b0100); step(); #1;
        chk("R3", "rot3", grant, 4'b1000); step(); #1;
        chk("R3", "rot4", grant, 4'b0001);
    endtask

    // R4: speculative threads rank last
    task automatic t_spec();
        do_reset();
        thr_ready = 4'b1111; thr_spec = 4'b0001; #1;
        chk("R4", "skip spec", grant, 4'b0010);
        thr_spec = 4'b1111; #1;
        chk("R4", "all spec oldest", grant, 4'b0001);
        thr_spec = 4'b0111; #1;
        chk("R4", "only nonspec", grant, 4'b1000);
        thr_spec = '0;
    endtask

    // R8 R2: the age order holds through bubbles and updates only on grant
    task automatic t_hold();
        do_reset();
        thr_ready = '0; #1;
        chk("R8", "bubble", grant, 4'b0000);
        step(); step();
        thr_ready = 4'b0100; #1;
        chk("R2", "lone ready", grant, 4'b0100);
        step();
        thr_ready = 4'b1111; #1;
        chk("R8", "order kept", grant, 4'b0001);
        step(); #1;
        chk("R2", "after 2 and 0", grant, 4'b0010);
    endtask

    // R5: a long-latency op holds the thread out
    task automatic t_lat();
        do_reset();
        thr_ready = 4'b0001; lat_start = 4'b0001; #1;
        chk("R5", "grant at start", grant, 4'b0001);
        step(); clear_ev(); #1;
        chk("R5", "held", grant, 4'b0000);
        step(); #1;
        chk("R5", "still held", grant, 4'b0000);
        lat_done = 4'b0001; #1;
        chk("R5", "held on done", grant, 4'b0000);
        step(); clear_ev(); #1;
        chk("R5", "back", grant, 4'b0001);
    endtask

    // R6: a late trap flushes only that thread and holds it out
    task automatic t_trap();
        do_reset();
        thr_ready = 4'b1111; trap = 4'b0100; #1;
        chk("R6", "no flush yet", flush, 4'b0000);
        step(); clear_ev(); thr_ready = 4'b0100; #1;
        chk("R6", "flush pulse", flush, 4'b0100);
        chk("R6", "trap held", grant, 4'b0000);
        step(); #1;
        chk("R6", "flush one cycle", flush, 4'b0000);
        trap_clr = 4'b0100; #1;
        chk("R6", "held on clr", grant, 4'b0000);
        step(); clear_ev(); #1;
        chk("R6", "back", grant, 4'b0100);
    endtask

    // R7: when events collide the deselect wins
    task automatic t_conflict();
        do_reset();
        thr_ready = 4'b0010; lat_start = 4'b0010; lat_done = 4'b0010;
        step(); clear_ev(); #1;
        chk("R7", "lat collide", grant, 4'b0000);
        lat_done = 4'b0010; step(); clear_ev(); #1;
        chk("R7", "lat release", grant, 4'b0010);
        thr_ready = 4'b1000; trap = 4'b1000; trap_clr = 4'b1000;
        step(); clear_ev(); #1;
        chk("R7", "trap collide", grant, 4'b0000);
    endtask

    // R9: threads that are not ready are skipped
    task automatic t_ready();
        do_reset();
        thr_ready = 4'b1010; #1;
        chk("R9", "first", grant, 4'b0010); step(); #1;
        chk("R9", "second", grant, 4'b1000); step(); #1;
        chk("R9", "third", grant, 4'b0010);
    endtask

    initial begin
        t_reset();
        t_rotate();
        t_spec();
        t_hold();
        t_lat();
        t_trap();
        t_conflict();
        t_ready();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule